// File: doc/BRIEF.md
# Decode-Stage Branch Resolution Controller

This block is the branch control for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Fetch always assumes a conditional branch is not taken. The controller settles the branch direction while the branch is still in decode, using forwarded operands where they are available. On a taken branch it cancels the wrong-path instructions and steers the program counter to the branch target.

If the instruction directly ahead of the branch (now in execute) writes a register that the branch compares, that value does not exist yet. The controller then holds the branch's fields for one cycle and resolves it while the branch sits in execute, using the value forwarded from the memory stage. A taken branch therefore costs one slot when resolved early and two slots when resolved late. A not-taken branch costs nothing. A running counter adds up every squashed slot so that a surrounding environment can compare total lost cycles against a reference.

Supported compares are equal and not-equal on two register operands. The target is the branch PC plus four plus the sign-extended offset shifted left by two.

Top module: `bhc_branch_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `lost_cycles` clears to 0. After reset, with no valid branch in decode and nothing deferred, `pc_sel`, `flush_if`, `flush_id` and `dep_wait` are all 0.
- R2: A valid branch in decode with no dependency on the execute stage that compares not taken raises no redirect and no flush, and leaves `lost_cycles` unchanged.
- R3: A valid branch in decode with no execute-stage dependency that compares taken raises `pc_sel` and `flush_if` in that same cycle, keeps `flush_id` low, and drives `pc_target` = `id_pc` + 4 + (sign-extended `id_imm` << 2). `lost_cycles` rises by 1 at the next edge.
- R4: When `ex_we` is 1 and a nonzero `ex_rd` equals `id_rs` or `id_rt` of a valid decode branch, `dep_wait` is 1 and `pc_sel` stays 0 in that cycle.
- R5: A branch deferred by R4 is resolved in the next cycle. If taken, `pc_sel`, `flush_if` and `flush_id` are all 1 and `pc_target` is that branch's own target. `lost_cycles` rises by 2 at the following edge.
- R6: A deferred branch that resolves not taken raises no flush of its own and adds nothing to `lost_cycles`.
- R7: Each compared operand takes the memory-stage result when `mem_we` is set and `mem_rd` matches. Otherwise it takes the writeback-stage result when `wb_we` is set and `wb_rd` matches. Otherwise it takes the register-file read data. A deferred branch keeps the register-file data captured in its decode cycle.
- R8: Register 0 is never a dependency or a forwarding source. `ex_rd` = 0 never raises `dep_wait`, and a memory or writeback write to register 0 is not forwarded.
- R9: `id_bne` = 0 selects the equal compare (taken when the operands match). `id_bne` = 1 selects the not-equal compare (taken when they differ).
- R10: While a deferred branch resolves taken, the instruction in decode is on the wrong path and is ignored as a branch. `pc_target` and the `lost_cycles` increment come only from the deferred branch. When the deferred branch is not taken, a branch in decode resolves normally in that cycle.
- R11: A decode entry with `id_valid` = 0 or `id_is_branch` = 0 never causes a redirect, a flush or a counter change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode stage holds a live instruction |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| id_bne | input | 1 | 0 = branch if equal, 1 = branch if not equal |
| id_rs | input | 5 | First compared register |
| id_rt | input | 5 | Second compared register |
| id_pc | input | 32 | PC of the decode instruction |
| id_imm | input | 16 | Branch word offset |
| rf_rs_data | input | 32 | Register-file read data for `id_rs` |
| rf_rt_data | input | 32 | Register-file read data for `id_rt` |
| ex_we | input | 1 | Execute-stage instruction writes a register |
| ex_rd | input | 5 | Execute-stage destination register |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_rd | input | 5 | Memory-stage destination register |
| mem_data | input | 32 | Memory-stage result available for forwarding |
| wb_we | input | 1 | Writeback-stage instruction writes a register |
| wb_rd | input | 5 | Writeback-stage destination register |
| wb_data | input | 32 | Writeback-stage result available for forwarding |
| pc_sel | output | 1 | 1 = next PC is `pc_target` |
| pc_target | output | 32 | Branch target for the redirect |
| flush_if | output | 1 | Cancel the instruction in fetch |
| flush_id | output | 1 | Cancel the instruction in decode |
| dep_wait | output | 1 | Decode branch deferred by one cycle |
| lost_cycles | output | 32 | Total squashed slots |

## Verification
The assertions assume that the surrounding pipeline honours each squash. After a late taken resolution, the next decode entry does not itself carry an execute-stage dependency that was produced on the wrong path. The assertions also assume that register-file reads already reflect a write in the same cycle. The stimulus follows these assumptions by idling the execute-stage write on the wrong-path cycle. It also drives every forwarding case with the correct value in exactly one source and stale values everywhere else. Branch kind, operand source and outcome are swept exhaustively, so each redirect, flush and counter step is predicted from the operand values alone.

// File: rtl/bhc_pkg.sv
package bhc_pkg;
  typedef enum logic {
    CMP_EQ = 1'b0,
    CMP_NE = 1'b1
  } cmp_kind_e;

  localparam int NUM_PATHS = 2;
  localparam int NUM_OPS   = 2;
endpackage

// File: rtl/bhc_fwd_sel.sv
module bhc_fwd_sel #(
  parameter int XLEN = 32,
  parameter int RW   = 5
) (
  input  logic [RW-1:0]   src,
  input  logic [XLEN-1:0] rf_data,
  input  logic            mem_we,
  input  logic [RW-1:0]   mem_rd,
  input  logic [XLEN-1:0] mem_data,
  input  logic            wb_we,
  input  logic [RW-1:0]   wb_rd,
  input  logic [XLEN-1:0] wb_data,
  output logic [XLEN-1:0] value
);
  logic hit_mem, hit_wb;

  assign hit_mem = mem_we && (mem_rd != '0) && (mem_rd == src);
  assign hit_wb  = wb_we  && (wb_rd  != '0) && (wb_rd  == src);

  always_comb begin
    if (hit_mem)     value = mem_data;
    else if (hit_wb) value = wb_data;
    else             value = rf_data;
  end
endmodule

// File: rtl/bhc_cmp.sv
module bhc_cmp
  import bhc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  cmp_kind_e       kind,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  output logic            taken
);
  logic same;

  assign same  = (op_a == op_b);
  assign taken = (kind == CMP_NE) ? !same : same;
endmodule

// File: rtl/bhc_lost_ctr.sv
module bhc_lost_ctr #(
  parameter int CNTW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      add,
  output logic [CNTW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + CNTW'(add);
  end
endmodule

// File: rtl/bhc_branch_ctrl.sv
module bhc_branch_ctrl
  import bhc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RW   = 5,
  parameter int IMMW = 16,
  parameter int CNTW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            id_valid,
  input  logic            id_is_branch,
  input  logic            id_bne,
  input  logic [RW-1:0]   id_rs,
  input  logic [RW-1:0]   id_rt,
  input  logic [XLEN-1:0] id_pc,
  input  logic [IMMW-1:0] id_imm,
  input  logic [XLEN-1:0] rf_rs_data,
  input  logic [XLEN-1:0] rf_rt_data,
  input  logic            ex_we,
  input  logic [RW-1:0]   ex_rd,
  input  logic            mem_we,
  input  logic [RW-1:0]   mem_rd,
  input  logic [XLEN-1:0] mem_data,
  input  logic            wb_we,
  input  logic [RW-1:0]   wb_rd,
  input  logic [XLEN-1:0] wb_data,
  output logic            pc_sel,
  output logic [XLEN-1:0] pc_target,
  output logic            flush_if,
  output logic            flush_id,
  output logic            dep_wait,
  output logic [CNTW-1:0] lost_cycles
);
  localparam int EXTW = XLEN - IMMW - 2;

  // Path 0 = branch in decode, path 1 = branch deferred into execute.
  logic            pend_valid;
  cmp_kind_e       pend_kind;
  logic [RW-1:0]   pend_rs, pend_rt;
  logic [XLEN-1:0] pend_rs_data, pend_rt_data, pend_target;

  logic [XLEN-1:0] id_target;
  logic            id_br, dep_hit, late_taken, id_live, early_taken;
  logic [1:0]      lost_add;

  logic [RW-1:0]   p_src  [NUM_PATHS][NUM_OPS];
  logic [XLEN-1:0] p_rf   [NUM_PATHS][NUM_OPS];
  logic [XLEN-1:0] p_val  [NUM_PATHS][NUM_OPS];
  cmp_kind_e       p_kind [NUM_PATHS];
  logic            p_taken[NUM_PATHS];

  assign id_target = id_pc + XLEN'(4) + {{EXTW{id_imm[IMMW-1]}}, id_imm, 2'b00};

  assign p_src[0][0] = id_rs;
  assign p_src[0][1] = id_rt;
  assign p_rf[0][0]  = rf_rs_data;
  assign p_rf[0][1]  = rf_rt_data;
  assign p_kind[0]   = id_bne ? CMP_NE : CMP_EQ;
  assign p_src[1][0] = pend_rs;
  assign p_src[1][1] = pend_rt;
  assign p_rf[1][0]  = pend_rs_data;
  assign p_rf[1][1]  = pend_rt_data;
  assign p_kind[1]   = pend_kind;

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    for (genvar o = 0; o < NUM_OPS; o++) begin : g_op
      bhc_fwd_sel #(.XLEN(XLEN), .RW(RW)) u_fwd (
        .src      (p_src[p][o]),
        .rf_data  (p_rf[p][o]),
        .mem_we   (mem_we),
        .mem_rd   (mem_rd),
        .mem_data (mem_data),
        .wb_we    (wb_we),
        .wb_rd    (wb_rd),
        .wb_data  (wb_data),
        .value    (p_val[p][o])
      );
    end
    bhc_cmp #(.XLEN(XLEN)) u_cmp (
      .kind  (p_kind[p]),
      .op_a  (p_val[p][0]),
      .op_b  (p_val[p][1]),
      .taken (p_taken[p])
    );
  end

  assign id_br       = id_valid && id_is_branch;
  assign dep_hit     = ex_we && (ex_rd != '0) && ((ex_rd == id_rs) || (ex_rd == id_rt));
  assign late_taken  = pend_valid && p_taken[1];
  assign id_live     = id_br && !late_taken;
  assign dep_wait    = id_live && dep_hit;
  assign early_taken = id_live && !dep_hit && p_taken[0];

  assign pc_sel    = late_taken || early_taken;
  assign pc_target = late_taken ? pend_target : id_target;
  assign flush_if  = pc_sel;
  assign flush_id  = late_taken;
  assign lost_add  = late_taken ? 2'd2 : (early_taken ? 2'd1 : 2'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
    end else begin
      pend_valid <= dep_wait;
    end
  end

  always_ff @(posedge clk) begin
    if (dep_wait) begin
      pend_kind    <= p_kind[0];
      pend_rs      <= id_rs;
      pend_rt      <= id_rt;
      pend_rs_data <= rf_rs_data;
      pend_rt_data <= rf_rt_data;
      pend_target  <= id_target;
    end
  end

  bhc_lost_ctr #(.CNTW(CNTW)) u_ctr (
    .clk   (clk),
    .rst   (rst),
    .add   (lost_add),
    .count (lost_cycles)
  );
endmodule

// File: rtl/bhc_branch_ctrl_chk.sv
module bhc_branch_ctrl_chk #(
  parameter int RW   = 5,
  parameter int CNTW = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            id_valid,
  input logic            id_is_branch,
  input logic            ex_we,
  input logic [RW-1:0]   ex_rd,
  input logic            pc_sel,
  input logic            flush_if,
  input logic            flush_id,
  input logic            dep_wait,
  input logic [CNTW-1:0] lost_cycles
);
  // R3: a redirect always cancels the fetch slot
  a_r3_redirect_flushes_fetch: assert property (@(posedge clk) disable iff (rst)
    pc_sel |-> flush_if);

  // R3: an early taken branch costs exactly one slot
  a_r3_early_costs_one: assert property (@(posedge clk) disable iff (rst)
    (pc_sel && !flush_id) |=> (lost_cycles == $past(lost_cycles) + CNTW'(1)));

  // R4: a deferred branch never redirects in its decode cycle
  a_r4_wait_no_redirect: assert property (@(posedge clk) disable iff (rst)
    dep_wait |-> !pc_sel);

  // R5: a decode flush only follows a deferral and costs two slots
  a_r5_late_follows_wait: assert property (@(posedge clk) disable iff (rst)
    flush_id |-> ($past(dep_wait) && pc_sel));

  a_r5_late_costs_two: assert property (@(posedge clk) disable iff (rst)
    flush_id |=> (lost_cycles == $past(lost_cycles) + CNTW'(2)));

  // R2: no redirect, no lost cycle
  a_r2_idle_counter_stable: assert property (@(posedge clk) disable iff (rst)
    !pc_sel |=> $stable(lost_cycles));

  // R8: register zero is never a dependency
  a_r8_zero_no_wait: assert property (@(posedge clk) disable iff (rst)
    (ex_we && ex_rd == '0) |-> !dep_wait);

  // R11: no branch in decode, no deferral
  a_r11_nonbranch_no_wait: assert property (@(posedge clk) disable iff (rst)
    !(id_valid && id_is_branch) |-> !dep_wait);
endmodule

bind bhc_branch_ctrl bhc_branch_ctrl_chk #(.RW(RW), .CNTW(CNTW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .id_valid     (id_valid),
  .id_is_branch (id_is_branch),
  .ex_we        (ex_we),
  .ex_rd        (ex_rd),
  .pc_sel       (pc_sel),
  .flush_if     (flush_if),
  .flush_id     (flush_id),
  .dep_wait     (dep_wait),
  .lost_cycles  (lost_cycles)
);

// File: tb/tb_bhc_branch_ctrl.sv
module tb_bhc_branch_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        id_valid, id_is_branch, id_bne;
  logic [4:0]  id_rs, id_rt, ex_rd, mem_rd, wb_rd;
  logic [31:0] id_pc, rf_rs_data, rf_rt_data, mem_data, wb_data;
  logic [15:0] id_imm;
  logic        ex_we, mem_we, wb_we;
  logic        pc_sel, flush_if, flush_id, dep_wait;
  logic [31:0] pc_target, lost_cycles;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_lost = 0;

  always #5 clk = ~clk;

  bhc_branch_ctrl dut (
    .clk(clk), .rst(rst), .id_valid(id_valid), .id_is_branch(id_is_branch),
    .id_bne(id_bne), .id_rs(id_rs), .id_rt(id_rt), .id_pc(id_pc), .id_imm(id_imm),
    .rf_rs_data(rf_rs_data), .rf_rt_data(rf_rt_data), .ex_we(ex_we), .ex_rd(ex_rd),
    .mem_we(mem_we), .mem_rd(mem_rd), .mem_data(mem_data), .wb_we(wb_we),
    .wb_rd(wb_rd), .wb_data(wb_data), .pc_sel(pc_sel), .pc_target(pc_target),
    .flush_if(flush_if), .flush_id(flush_id), .dep_wait(dep_wait),
    .lost_cycles(lost_cycles)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    id_valid = 0; id_is_branch = 0; id_bne = 0; id_rs = 0; id_rt = 0;
    id_pc = 0; id_imm = 0; rf_rs_data = 0; rf_rt_data = 0;
    ex_we = 0; ex_rd = 0; mem_we = 0; mem_rd = 0; mem_data = 0;
    wb_we = 0; wb_rd = 0; wb_data = 0;
  endtask

  function automatic logic [31:0] tgt(input logic [31:0] pc, input logic [15:0] imm);
    return pc + 32'd4 + {{14{imm[15]}}, imm, 2'b00};
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    chk("R1", "lost_cycles", lost_cycles, 0);
    chk("R1", "pc_sel", {31'b0, pc_sel}, 0);
    chk("R1", "flush", {30'b0, flush_if, flush_id}, 0);
    chk("R1", "dep_wait", {31'b0, dep_wait}, 0);

    // Sweep: kind x operand source x outcome
    for (int kind = 0; kind < 2; kind++) begin
      for (int src = 0; src < 6; src++) begin
        for (int eq = 0; eq < 2; eq++) begin
          logic [31:0] a_val, b_val, pc, exp_t;
          logic [15:0] imm;
          logic late, taken;
          a_val = (src == 5) ? 32'd0 : 32'd100;
          b_val = eq ? a_val : a_val + 32'd7;
          pc    = 32'h1000 + 32'(src * 64 + kind * 16 + eq * 4);
          imm   = (src[0]) ? 16'hFFF0 : 16'h0008;
          exp_t = tgt(pc, imm);
          late  = (src == 1 || src == 2);
          taken = kind ? (a_val != b_val) : (a_val == b_val); // R9

          @(negedge clk);
          idle();
          id_valid = 1; id_is_branch = 1; id_bne = kind[0];
          id_rs = 3; id_rt = 4; id_pc = pc; id_imm = imm;
          rf_rs_data = a_val; rf_rt_data = b_val;
          case (src)
            1: begin ex_we = 1; ex_rd = 3; rf_rs_data = 32'd888; end
            2: begin ex_we = 1; ex_rd = 4; rf_rt_data = 32'd888; end
            3: begin // R7 memory over writeback over register file
              mem_we = 1; mem_rd = 3; mem_data = a_val;
              wb_we = 1; wb_rd = 3; wb_data = 32'd999; rf_rs_data = 32'd888;
            end
            4: begin wb_we = 1; wb_rd = 4; wb_data = b_val; rf_rt_data = 32'd888; end
            5: begin // R8 register zero
              id_rs = 0; ex_we = 1; ex_rd = 0;
              mem_we = 1; mem_rd = 0; mem_data = 32'd55;
            end
            default: ;
          endcase
          #1;
          if (late) begin
            chk("R4", "dep_wait", {31'b0, dep_wait}, 1);
            chk("R4", "pc_sel", {31'b0, pc_sel}, 0);
          end else begin
            chk(src == 5 ? "R8" : "R4", "dep_wait", {31'b0, dep_wait}, 0);
            chk(taken ? "R3" : "R2", "pc_sel", {31'b0, pc_sel}, {31'b0, taken});
            chk(taken ? "R3" : "R2", "flush_if", {31'b0, flush_if}, {31'b0, taken});
            chk("R3", "flush_id", {31'b0, flush_id}, 0);
            if (taken) chk(src >= 3 ? "R7" : "R3", "pc_target", pc_target, exp_t);
            if (taken) exp_lost += 1;
          end

          if (late) begin
            @(negedge clk);
            idle();
            // producer moved to memory stage; wrong-path taken branch in decode
            mem_we = 1; mem_rd = (src == 1) ? 5'd3 : 5'd4;
            mem_data = (src == 1) ? a_val : b_val;
            id_valid = 1; id_is_branch = 1; id_bne = 0; id_rs = 5; id_rt = 5;
            id_pc = 32'h8000; id_imm = 0; rf_rs_data = 9; rf_rt_data = 9;
            #1;
            if (taken) begin
              chk("R5", "pc_sel", {31'b0, pc_sel}, 1);
              chk("R5", "flush", {30'b0, flush_if, flush_id}, 32'd3);
              chk("R10", "pc_target", pc_target, exp_t);
              exp_lost += 2;
            end else begin
              chk("R6", "flush_id", {31'b0, flush_id}, 0);
              chk("R10", "pc_sel", {31'b0, pc_sel}, 1);
              chk("R10", "pc_target", pc_target, 32'h8004);
              exp_lost += 1;
            end
          end

          @(negedge clk);
          idle();
          #1;
          chk(late ? (taken ? "R5" : "R6") : (taken ? "R3" : "R2"),
              "lost_cycles", lost_cycles, exp_lost);
        end
      end
    end

    // R11: invalid or non-branch decode entries
    for (int m = 0; m < 2; m++) begin
      @(negedge clk);
      idle();
      id_valid = m[0]; id_is_branch = !m[0]; id_rs = 6; id_rt = 6;
      rf_rs_data = 5; rf_rt_data = 5; id_pc = 32'h40;
      ex_we = 1; ex_rd = 6;
      #1;
      chk("R11", "pc_sel", {31'b0, pc_sel}, 0);
      chk("R11", "dep_wait", {31'b0, dep_wait}, 0);
      @(negedge clk);
      idle();
      #1;
      chk("R11", "flush", {30'b0, flush_if, flush_id}, 0);
      chk("R11", "lost_cycles", lost_cycles, exp_lost);
    end

    // R1: reset clears the counter
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    #1;
    chk("R1", "lost_cycles after reset", lost_cycles, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule